// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with 16 address bits and a 4-bit shared data bus. The host offers one word access at a time on a valid/ready request carrying an address, write data and a write flag. The controller turns it into a strobe sequence on the RAM pins: active-low chip select, write strobe and output enable. It also runs the tristate enable of the data bus, registers read data and answers with a one-cycle done pulse.

All RAM timing is counted in whole clock cycles set by parameters. At a 4 ns clock the defaults meet the fastest speed grade: 3 cycles of access time, a 2-cycle write data window and 2 cycles of turnaround when there is no output-enable pin. One parameter builds a variant without an output-enable pin, where the RAM drives the bus whenever it is selected and not writing. A second parameter chooses between deselecting the RAM while idle, which saves standby power, and keeping it selected between accesses.

Top module: `asram_if_ctrl`

## Requirements
- R1: Out of reset: chip select is high when `KEEP_SELECTED`=0 and low when it is 1, the write strobe is high, the output enable is high, the data bus is not driven, `reqReady` is 1 and `rspDone` is 0.
- R2: A read drives the address and pulls chip select low in the cycle that follows the accepting edge, with the write strobe high and the output enable low when that pin exists. It registers the bus on the `ACCESS_CYC`-th edge after acceptance and raises `rspDone` on the next edge.
- R3: A write keeps chip select low and the address unchanged while the write strobe is low. The strobe stays low for `WDATA_CYC` cycles plus the turnaround gap, and `rspDone` rises `WDATA_CYC`+2+gap edges after acceptance.
- R4: The data bus is driven only during the last `WDATA_CYC` cycles that the write strobe is low. It is released on the edge where the strobe rises and never overlaps a cycle in which the RAM may still be driving.
- R5: When the output-enable pin exists, it stays high for the whole write, and the turnaround gap is zero cycles.
- R6: When `HAS_OE`=0, the output-enable pin is held high. The bus is driven only after `HIZ_CYC` cycles of the write strobe being low, because the RAM keeps driving until then.
- R7: `reqReady` is 1 only when no access is in progress and drops in the cycle after acceptance. Only one access is outstanding at a time.
- R8: Between accesses, chip select is high when `KEEP_SELECTED`=0 and stays low when it is 1.
- R9: `rspDone` lasts exactly one cycle. `rspData` keeps the last value read through later writes.
- R10: A read returns the value last written to that address, including addresses 0x0000 and 0xFFFF. An address never written reads as 0 in the bench's RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| reqWe | input | 1 | 1 = write, 0 = read |
| rspData | output | DATA_W | Registered read data |
| rspDone | output | 1 | One-cycle completion pulse |
| memAddr | output | ADDR_W | RAM address pins |
| memCeN | output | 1 | RAM chip select, active low |
| memWeN | output | 1 | RAM write strobe, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memDqOut | output | DATA_W | Data driven toward the RAM |
| memDqOe | output | 1 | Tristate enable of the data pads |
| memDqIn | input | DATA_W | Data returned from the RAM pads |

## Verification
The assertions assume the host holds `reqValid` and the request fields steady until the cycle in which `reqReady` accepts them, and issues nothing else while an access is running. The bench driver raises a request only at a falling edge, waits for acceptance and then lowers `reqValid` until `rspDone`. Random traffic is limited to a few addresses so that overwrites and read-after-write pairs happen often. The bench's RAM model keeps driving for `HIZ_CYC` cycles after it is deselected or its output is disabled. It holds read data undefined until the address has been stable for `ACCESS_CYC` samples, so early capture or premature driving shows up.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WGAP,
    ST_WDRIVE,
    ST_WEND,
    ST_RACC,
    ST_REND
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selOn;    // chip select active
    logic writeOn;  // write strobe active
    logic readOn;   // output enable active
    logic driveOn;  // controller drives data bus
    logic capture;  // register read data this edge
    logic load;     // latch request fields this edge
  } strobe_t;

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int ACCESS_CYC    = 3,
  parameter int HIZ_CYC       = 2,
  parameter int WDATA_CYC     = 2,
  parameter bit HAS_OE        = 1'b1,
  parameter bit KEEP_SELECTED = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWe,
  output logic    reqReady,
  output strobe_t strb,
  output logic    rspDone
);

  localparam int GAP_CYC = HAS_OE ? 0 : HIZ_CYC;
  localparam int MAX_A   = (ACCESS_CYC > WDATA_CYC) ? ACCESS_CYC : WDATA_CYC;
  localparam int MAX_C   = (MAX_A > HIZ_CYC) ? MAX_A : HIZ_CYC;
  localparam int CNT_W   = $clog2(MAX_C + 1);

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rspDone <= 1'b0;
    end else begin
      rspDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqWe) begin
              state <= ST_WSETUP;
            end else begin
              state <= ST_RACC;
              cnt   <= CNT_W'(ACCESS_CYC - 1);
            end
          end
        end
        ST_WSETUP: begin
          if (GAP_CYC > 0) begin
            state <= ST_WGAP;
            cnt   <= CNT_W'(GAP_CYC - 1);
          end else begin
            state <= ST_WDRIVE;
            cnt   <= CNT_W'(WDATA_CYC - 1);
          end
        end
        ST_WGAP: begin
          if (cntZero) begin
            state <= ST_WDRIVE;
            cnt   <= CNT_W'(WDATA_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WDRIVE: begin
          if (cntZero) state <= ST_WEND;
          else         cnt   <= cnt - 1'b1;
        end
        ST_RACC: begin
          if (cntZero) state <= ST_REND;
          else         cnt   <= cnt - 1'b1;
        end
        ST_WEND, ST_REND: begin
          state   <= ST_IDLE;
          rspDone <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.selOn   = (state != ST_IDLE) || KEEP_SELECTED;
    strb.writeOn = (state == ST_WGAP) || (state == ST_WDRIVE);
    strb.readOn  = (state == ST_RACC) || (state == ST_REND);
    strb.driveOn = (state == ST_WDRIVE);
    strb.capture = (state == ST_RACC) && cntZero;
    strb.load    = (state == ST_IDLE) && reqValid;
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4,
  parameter bit HAS_OE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memCeN   = ~strb.selOn;
  assign memWeN   = ~strb.writeOn;
  assign memDqOut = wdataQ;
  assign memDqOe  = strb.driveOn;
  assign rspData  = rdataQ;

  if (HAS_OE) begin : g_oe
    assign memOeN = ~strb.readOn;
  end else begin : g_no_oe
    assign memOeN = 1'b1;
  end

endmodule

// File: rtl/asram_if_ctrl.sv
module asram_if_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 4,
  parameter int ACCESS_CYC    = 3,
  parameter int HIZ_CYC       = 2,
  parameter int WDATA_CYC     = 2,
  parameter bit HAS_OE        = 1'b1,
  parameter bit KEEP_SELECTED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWe,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;

  asram_ctrl_fsm #(
    .ACCESS_CYC(ACCESS_CYC), .HIZ_CYC(HIZ_CYC), .WDATA_CYC(WDATA_CYC),
    .HAS_OE(HAS_OE), .KEEP_SELECTED(KEEP_SELECTED)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWe(reqWe),
    .reqReady(reqReady), .strb(strb), .rspDone(rspDone)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_OE(HAS_OE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDqIn(memDqIn), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .rspData(rspData)
  );

endmodule

// File: rtl/asram_if_ctrl_chk.sv
module asram_if_ctrl_chk #(
  parameter int ADDR_W        = 16,
  parameter bit HAS_OE        = 1'b1,
  parameter bit KEEP_SELECTED = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe
);

  // R4
  drive_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memCeN && !memWeN));

  // R4
  release_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memDqOe);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memWeN) |=> $stable(memAddr));

  // R3
  ce_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN) |=> (!memCeN));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  if (HAS_OE) begin : g_oe_chk
    // R5
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!memWeN) |-> memOeN);
  end else begin : g_no_oe_chk
    // R6
    oe_tied_chk: assert property (@(posedge clk) disable iff (!rstN)
      memOeN);
  end

  if (!KEEP_SELECTED) begin : g_park_chk
    // R8
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
      reqReady |-> memCeN);
  end else begin : g_keep_chk
    // R8
    idle_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
      reqReady |-> !memCeN);
  end

endmodule

bind asram_if_ctrl asram_if_ctrl_chk #(
  .ADDR_W(ADDR_W), .HAS_OE(HAS_OE), .KEEP_SELECTED(KEEP_SELECTED)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspDone(rspDone), .memAddr(memAddr), .memCeN(memCeN),
  .memWeN(memWeN), .memOeN(memOeN), .memDqOe(memDqOe)
);

// File: tb/asram_if_ctrl_tb.sv
module asram_if_ctrl_tb;

  localparam int ACC = 3;
  localparam int HIZ = 2;
  localparam int WD  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rstN;

  int checks = 0;
  int errors = 0;

  logic        reqValid [2];
  logic        reqWe    [2];
  logic        reqReady [2];
  logic        rspDone  [2];
  logic        memCeN   [2];
  logic        memWeN   [2];
  logic        memOeN   [2];
  logic        memDqOe  [2];
  logic [15:0] reqAddr  [2];
  logic [15:0] memAddr  [2];
  logic [3:0]  reqWdata [2];
  logic [3:0]  rspData  [2];
  logic [3:0]  memDqOut [2];
  logic [3:0]  memDqIn  [2];

  typedef struct {
    bit         isRead;
    logic [3:0] data;
  } exp_t;

  exp_t       expQ0[$];
  exp_t       expQ1[$];
  logic [3:0] shadow0[int];
  logic [3:0] shadow1[int];
  logic [3:0] ram0[int];
  logic [3:0] ram1[int];

  // lane 0: with output enable, deselect when idle
  asram_if_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqReady(reqReady[0]),
    .reqAddr(reqAddr[0]), .reqWdata(reqWdata[0]), .reqWe(reqWe[0]),
    .rspData(rspData[0]), .rspDone(rspDone[0]), .memAddr(memAddr[0]),
    .memCeN(memCeN[0]), .memWeN(memWeN[0]), .memOeN(memOeN[0]),
    .memDqOut(memDqOut[0]), .memDqOe(memDqOe[0]), .memDqIn(memDqIn[0])
  );

  // lane 1: no output enable, stay selected when idle
  asram_if_ctrl #(.HAS_OE(1'b0), .KEEP_SELECTED(1'b1)) u_dut_nooe (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqReady(reqReady[1]),
    .reqAddr(reqAddr[1]), .reqWdata(reqWdata[1]), .reqWe(reqWe[1]),
    .rspData(rspData[1]), .rspDone(rspDone[1]), .memAddr(memAddr[1]),
    .memCeN(memCeN[1]), .memWeN(memWeN[1]), .memOeN(memOeN[1]),
    .memDqOut(memDqOut[1]), .memDqOe(memDqOe[1]), .memDqIn(memDqIn[1])
  );

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  function automatic logic [3:0] ramGet(int ln, logic [15:0] a);
    if (ln == 0) return ram0.exists(a) ? ram0[a] : 4'h0;
    return ram1.exists(a) ? ram1[a] : 4'h0;
  endfunction

  function automatic logic [3:0] shadowGet(int ln, logic [15:0] a);
    if (ln == 0) return shadow0.exists(a) ? shadow0[a] : 4'h0;
    return shadow1.exists(a) ? shadow1[a] : 4'h0;
  endfunction

  // behavioural RAM model and pin-level timing monitor
  bit         prevWr   [2];
  bit         prevOn   [2];
  bit         wrBad    [2];
  bit         oeBad    [2];
  int         linger   [2];
  int         weLowCnt [2];
  int         driveCnt [2];
  int         accCnt   [2];
  logic [3:0] lastData [2];
  logic [15:0] wrAddr  [2];
  logic [15:0] prevAddr[2];

  initial begin
    for (int ln = 0; ln < 2; ln++) begin
      prevWr[ln] = 0; prevOn[ln] = 0; linger[ln] = 0; accCnt[ln] = 0;
      wrBad[ln] = 0; oeBad[ln] = 0; memDqIn[ln] = 'x; prevAddr[ln] = '0;
      weLowCnt[ln] = 0; driveCnt[ln] = 0; lastData[ln] = '0; wrAddr[ln] = '0;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int ln = 0; ln < 2; ln++) begin
        bit wrNow, ramOn, busy;
        wrNow = !memCeN[ln] && !memWeN[ln];
        ramOn = !memCeN[ln] && memWeN[ln] && (ln == 1 || !memOeN[ln]);
        busy  = ramOn || (linger[ln] > 0);
        if (ln == 1 && !memOeN[ln]) oeBad[ln] = 1;  // R6
        if (memDqOe[ln]) begin
          checks++;
          if (busy || !wrNow) fail("R4", "bus drive overlap", memDqOe[ln], 0);
        end
        if (wrNow) begin
          if (!prevWr[ln]) begin
            weLowCnt[ln] = 0; driveCnt[ln] = 0; wrAddr[ln] = memAddr[ln]; wrBad[ln] = 0;
          end
          weLowCnt[ln]++;
          if (memAddr[ln] != wrAddr[ln]) wrBad[ln] = 1;
          if (ln == 0 && !memOeN[ln]) oeBad[ln] = 1;  // R5
          if (memDqOe[ln]) begin
            driveCnt[ln]++;
            lastData[ln] = memDqOut[ln];
          end else begin
            driveCnt[ln] = 0;
          end
        end else if (prevWr[ln]) begin
          checks++;
          if (weLowCnt[ln] != WD + (ln == 1 ? HIZ : 0))
            fail("R3", "write strobe cycles", weLowCnt[ln], WD + (ln == 1 ? HIZ : 0));
          checks++;
          if (driveCnt[ln] != WD) fail("R4", "data setup cycles", driveCnt[ln], WD);
          checks++;
          if (wrBad[ln]) fail("R3", "address moved in write", 1, 0);
          checks++;
          if (oeBad[ln]) fail(ln == 0 ? "R5" : "R6", "output enable low", 1, 0);
          if (ln == 0) ram0[wrAddr[ln]] = lastData[ln];
          else         ram1[wrAddr[ln]] = lastData[ln];
        end
        if (ramOn && prevOn[ln] && memAddr[ln] == prevAddr[ln]) accCnt[ln]++;
        else accCnt[ln] = ramOn ? 1 : 0;
        memDqIn[ln] = (accCnt[ln] >= ACC) ? ramGet(ln, memAddr[ln]) : 4'hx;
        if (ramOn) linger[ln] = HIZ;
        else if (linger[ln] > 0) linger[ln]--;
        prevOn[ln]   = ramOn;
        prevWr[ln]   = wrNow;
        prevAddr[ln] = memAddr[ln];
      end
    end
  end

  // scoreboard monitor
  logic [3:0] lastRead [2];
  initial begin
    lastRead[0] = 4'h0;
    lastRead[1] = 4'h0;
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int ln = 0; ln < 2; ln++) begin
        if (rspDone[ln]) begin
          exp_t e;
          bit   empty;
          empty = (ln == 0) ? (expQ0.size() == 0) : (expQ1.size() == 0);
          checks++;
          if (empty) begin
            fail("R7", "done without request", 1, 0);
          end else begin
            e = (ln == 0) ? expQ0.pop_front() : expQ1.pop_front();
            checks++;
            if (e.isRead) begin
              if (rspData[ln] !== e.data) fail("R10", "read data", rspData[ln], e.data);
              lastRead[ln] = e.data;
            end else begin
              // R9: writes leave the read register alone
              if (rspData[ln] !== lastRead[ln]) fail("R9", "rdata changed by write", rspData[ln], lastRead[ln]);
            end
          end
        end
      end
    end
  end

  // driver
  task automatic doOp(int ln, bit wr, logic [15:0] a, logic [3:0] d);
    exp_t e;
    int   cnt;
    int   expLat;
    @(negedge clk);
    reqValid[ln] = 1'b1; reqWe[ln] = wr; reqAddr[ln] = a; reqWdata[ln] = d;
    while (!reqReady[ln]) @(negedge clk);
    e.isRead = !wr;
    e.data   = wr ? d : shadowGet(ln, a);
    if (ln == 0) expQ0.push_back(e); else expQ1.push_back(e);
    if (wr) begin
      if (ln == 0) shadow0[a] = d; else shadow1[a] = d;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid[ln] = 1'b0;
    cnt = 1;
    checks++;
    if (reqReady[ln]) fail("R7", "ready while busy", 1, 0);
    if (!wr) begin
      // R2: read strobes in the first access cycle
      checks++;
      if (memCeN[ln] || !memWeN[ln] || memAddr[ln] !== a || (ln == 0 && memOeN[ln]))
        fail("R2", "read strobes", {memCeN[ln], memWeN[ln], memOeN[ln]}, {1'b0, 1'b1, 1'b0});
    end
    while (!rspDone[ln] && cnt < 60) begin
      @(negedge clk);
      cnt++;
    end
    expLat = wr ? (WD + 3 + (ln == 1 ? HIZ : 0)) : (ACC + 2);
    checks++;
    if (cnt != expLat) fail(wr ? "R3" : "R2", "done latency", cnt, expLat);
    // R8: select level when idle again
    checks++;
    if (memCeN[ln] !== (ln == 0)) fail("R8", "idle select", memCeN[ln], ln == 0);
  endtask

  task automatic runLane(int ln);
    doOp(ln, 1, 16'h0000, 4'hA);
    doOp(ln, 1, 16'hFFFF, 4'h5);
    doOp(ln, 1, 16'h1234, 4'hC);
    doOp(ln, 0, 16'h0000, 4'h0);
    doOp(ln, 0, 16'hFFFF, 4'h0);
    doOp(ln, 0, 16'h1234, 4'h0);
    doOp(ln, 0, 16'h4321, 4'h0);
    doOp(ln, 1, 16'h1234, 4'h3);
    doOp(ln, 0, 16'h1234, 4'h0);
    doOp(ln, 1, 16'h8000, 4'hF);
    doOp(ln, 1, 16'h8000, 4'h0);
    doOp(ln, 0, 16'h8000, 4'h0);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a;
      a = {($urandom % 2) ? 8'hC3 : 8'h00, 5'd0, 3'($urandom % 8)};
      doOp(ln, 1'($urandom % 2), a, 4'($urandom % 16));
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int ln = 0; ln < 2; ln++) begin
      reqValid[ln] = 0; reqWe[ln] = 0; reqAddr[ln] = '0; reqWdata[ln] = '0;
    end
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int ln = 0; ln < 2; ln++) begin
      checks++;
      if (memCeN[ln] !== (ln == 0) || memWeN[ln] !== 1'b1 || memOeN[ln] !== 1'b1 ||
          memDqOe[ln] !== 1'b0 || reqReady[ln] !== 1'b1 || rspDone[ln] !== 1'b0)
        fail("R1", "reset state",
             {memCeN[ln], memWeN[ln], memOeN[ln], memDqOe[ln], reqReady[ln], rspDone[ln]},
             {ln == 0, 5'b11010});
    end
    runLane(0);
    runLane(1);
    repeat (5) @(negedge clk);
    checks++;
    if (expQ0.size() + expQ1.size() != 0)
      fail("R7", "outstanding items", expQ0.size() + expQ1.size(), 0);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule